// File: doc/BRIEF.md
# Multiplexed external memory bus controller

This block sits between a CPU's data-memory request port and an 8-bit multiplexed parallel bus. The low address byte and the data byte share one bus lane. The high address byte has its own lines. An address latch enable strobe tells an external transparent latch when to capture the low address. Active-low read and write strobes frame the data phase. Every request is classified by address. Addresses at or below the internal SRAM top (`INT_TOP`) go to an internal RAM port. Addresses above it go to the external bus, but only when the interface is enabled.

Each access runs through the same sequence. First comes one cycle with ALE high and the address on the lanes. Next comes one hold cycle with ALE low while the low address stays on the shared lane. Then the strobe phase lasts one cycle plus the selected number of wait cycles. Last comes one cycle in which the strobe is released and `cpu_ready` pulses.

Configuration inputs set four things: whether the interface owns the pins, how many top high-address bits are given back to other use, where the external space splits into a lower and an upper wait-state sector, and whether a bus keeper holds the shared lane. A compatibility input restricts the block to a reduced feature set.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, `cpu_ready` and `ale` are 0, `rd_n` and `wr_n` are 1, and `ad_oe` is 0.
- R2: With `cfg_en`=1, an address above `INT_TOP` (default 0x10FF) pulses `rd_n` or `wr_n` and never `int_en`. An address at or below `INT_TOP` pulses `int_en` for exactly one cycle and leaves both strobes high.
- R3: When `cfg_en`=1, `ale` is high for exactly one cycle per access. In that cycle `ad_o` carries `addr[7:0]` and `ah_o` carries `addr[15:8]`. In the cycle after `ale` falls, `ad_oe`=1 and `ad_o` still carries `addr[7:0]`.
- R4: The strobe is low for 1+W consecutive cycles, where W is the wait-state code. `cpu_ready` is high for exactly one cycle, starting in the cycle in which the strobe rises. Counting from the clock edge that accepts the request, ready appears after 3+L cycles, where L is the strobe length (1 for accesses with no strobe).
- R5: While `rd_n` is low, `ad_oe` is 0. The value on `ad_i` in the last low cycle is returned on `cpu_rdata` while `cpu_ready` is high.
- R6: While `wr_n` is low, `ad_oe` is 1 and `ad_o` carries the write data.
- R7: An external address whose bits [15:12] are below `cfg_split` uses `cfg_ws_lo`. Any other external address uses `cfg_ws_hi`. `cfg_split`=0 therefore puts all external space in the upper sector.
- R8: With `cfg_en`=0, the following stay inactive: `ad_oe`, `ah_oe`, `ctl_oe`, `ale`, and both strobes. A read above `INT_TOP` returns 0x00 without touching internal RAM. Internal accesses still work.
- R9: `ah_oe[i]` is 1 exactly when `cfg_en`=1 and i < 8 − `cfg_hi_rel`.
- R10: `ad_keep` is 1 exactly when `cfg_en`, `cfg_keeper` and not `cfg_compat` all hold and the lane is not driven. While `ad_keep` is 1, `ad_o` holds the last driven lane value.
- R11: With `cfg_compat`=1, three things change. The wait-state code is `{0, cfg_ws_hi[0]}` for all external addresses. All 8 high address bits are driven. `ad_keep` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cfg_en | input | 1 | Interface owns the bus pins |
| cfg_compat | input | 1 | Reduced-feature mode |
| cfg_hi_rel | input | 3 | Number of top high-address bits released |
| cfg_split | input | 4 | Sector boundary on address bits [15:12] |
| cfg_ws_lo | input | 2 | Wait states, lower sector |
| cfg_ws_hi | input | 2 | Wait states, upper sector |
| cfg_keeper | input | 1 | Bus keeper enable |
| ad_o | output | 8 | Shared address/data lane out |
| ad_oe | output | 1 | Shared lane drive enable |
| ad_i | input | 8 | Shared lane in |
| ad_keep | output | 1 | Weak hold of `ad_o` on the lane |
| ah_o | output | 8 | High address byte |
| ah_oe | output | 8 | Per-bit high address drive enable |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ctl_oe | output | 1 | Drive enable for ale, rd_n, wr_n |
| int_en | output | 1 | Internal RAM access, one cycle |
| int_we | output | 1 | Internal RAM write |
| int_addr | output | 16 | Internal RAM address |
| int_wdata | output | 8 | Internal RAM write data |
| int_rdata | input | 8 | Internal RAM read data, combinational |

## Verification
Once a request is accepted on a clock edge, the timing of each result is fixed:
- `ale` rises one cycle later.
- The address hold cycle follows one cycle after that.
- The strobe, or `int_en` for an internal access, starts in the third cycle and lasts 1+W cycles.
- `cpu_ready` and `cpu_rdata` follow in cycle 3+L.

The bench drives inputs and samples outputs on falling edges. At each falling edge it counts which phase it observes, and it checks the lane contents against the phase expected at that count. Read data is checked only at the falling edge where `cpu_ready` is high, and the total cycle count is compared with 3+L. The external SRAM and its address latch are modelled in the bench from `ale`, `ad_o` and the strobes alone.

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int AW = 16,
  parameter int SECW = 4,
  parameter logic [AW-1:0] INT_TOP = 16'h10FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          cpu_ready,
  input  logic          cfg_en,
  input  logic          cfg_compat,
  input  logic [2:0]    cfg_hi_rel,
  input  logic [SECW-1:0] cfg_split,
  input  logic [1:0]    cfg_ws_lo,
  input  logic [1:0]    cfg_ws_hi,
  input  logic          cfg_keeper,
  output logic [7:0]    ad_o,
  output logic          ad_oe,
  input  logic [7:0]    ad_i,
  output logic          ad_keep,
  output logic [AW-9:0] ah_o,
  output logic [AW-9:0] ah_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          ctl_oe,
  output logic          int_en,
  output logic          int_we,
  output logic [AW-1:0] int_addr,
  output logic [7:0]    int_wdata,
  input  logic [7:0]    int_rdata
);
  localparam int HW = AW - 8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_HOLD, S_STB, S_END} st_t;
  st_t st;

  logic [AW-1:0] a_q;
  logic [7:0]    wd_q, rd_q, lane_q;
  logic          we_q, ext_q, int_q;
  logic [1:0]    cnt;
  logic [1:0]    ws_code;
  logic [2:0]    hrel;
  logic          in_lower, drive_addr, drive_data, strobe;

  assign in_lower = a_q[AW-1 -: SECW] < cfg_split;
  assign ws_code  = cfg_compat ? {1'b0, cfg_ws_hi[0]} : (in_lower ? cfg_ws_lo : cfg_ws_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      a_q    <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      lane_q <= '0;
      we_q   <= 1'b0;
      ext_q  <= 1'b0;
      int_q  <= 1'b0;
      cnt    <= '0;
    end else begin
      if (ad_oe) lane_q <= ad_o;
      case (st)
        S_IDLE: if (cpu_req) begin
          a_q   <= cpu_addr;
          we_q  <= cpu_we;
          wd_q  <= cpu_wdata;
          ext_q <= cfg_en && (cpu_addr > INT_TOP);
          int_q <= cpu_addr <= INT_TOP;
          st    <= S_ADDR;
        end
        S_ADDR: st <= S_HOLD;
        S_HOLD: begin
          cnt <= ext_q ? ws_code : 2'd0;
          st  <= S_STB;
        end
        S_STB: begin
          if (cnt == 2'd0) begin
            rd_q <= int_q ? int_rdata : (ext_q ? ad_i : 8'h00);
            st   <= S_END;
          end else begin
            cnt <= cnt - 2'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign drive_addr = (st == S_ADDR) || (st == S_HOLD);
  assign drive_data = (st == S_STB) && we_q;
  assign strobe     = (st == S_STB) && ext_q;

  assign ad_oe   = cfg_en && (drive_addr || drive_data);
  assign ad_o    = drive_addr ? a_q[7:0] : (drive_data ? wd_q : lane_q);
  assign ad_keep = cfg_en && cfg_keeper && !cfg_compat && !ad_oe;
  assign ah_o    = a_q[AW-1:8];
  assign hrel    = cfg_compat ? 3'd0 : cfg_hi_rel;

  for (genvar i = 0; i < HW; i++) begin : g_ah
    assign ah_oe[i] = cfg_en && ((i + int'(hrel)) < HW);
  end

  assign ale    = cfg_en && (st == S_ADDR);
  assign rd_n   = !(strobe && !we_q);
  assign wr_n   = !(strobe && we_q);
  assign ctl_oe = cfg_en;

  assign int_en    = (st == S_STB) && int_q;
  assign int_we    = int_en && we_q;
  assign int_addr  = a_q;
  assign int_wdata = wd_q;

  assign cpu_ready = st == S_END;
  assign cpu_rdata = rd_q;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_ready,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ad_oe,
  input logic       ad_keep,
  input logic [7:0] ah_oe,
  input logic       ctl_oe,
  input logic       int_en,
  input logic       cfg_en,
  input logic       cfg_compat
);
  a_r4_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  a_r4_ready_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> cpu_ready);
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n) && !(int_en && (!rd_n || !wr_n)));
  a_r3_hold_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ad_oe);
  a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (!ad_oe && !ale && rd_n && wr_n && ah_oe == 8'h00 && !ctl_oe));
  a_r10_keeper_idle_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ad_keep |-> !ad_oe);
  a_r11_compat_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_compat) |-> (ah_oe == 8'hFF && !ad_keep));
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .ale(ale), .rd_n(rd_n),
  .wr_n(wr_n), .ad_oe(ad_oe), .ad_keep(ad_keep), .ah_oe(ah_oe),
  .ctl_oe(ctl_oe), .int_en(int_en), .cfg_en(cfg_en), .cfg_compat(cfg_compat)
);

// File: tb/xbus_ctrl_test.sv
`timescale 1ns/1ps
module xbus_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready;
  logic cfg_en = 1, cfg_compat = 0, cfg_keeper = 1;
  logic [2:0] cfg_hi_rel = 0;
  logic [3:0] cfg_split = 0;
  logic [1:0] cfg_ws_lo = 0, cfg_ws_hi = 0;
  logic [7:0] ad_o, ad_i, ah_o, ah_oe;
  logic ad_oe, ad_keep, ale, rd_n, wr_n, ctl_oe;
  logic int_en, int_we;
  logic [15:0] int_addr;
  logic [7:0] int_wdata, int_rdata;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  xbus_ctrl uut (.*);

  logic [7:0] xmem [256];
  logic [7:0] imem [256];
  logic [7:0] latch_q = '0;
  always @(negedge clk) begin
    if (ale) latch_q <= ad_o;
    if (!wr_n) xmem[latch_q] <= ad_o;
    if (int_en && int_we) imem[int_addr[7:0]] <= int_wdata;
  end
  assign ad_i = !rd_n ? xmem[latch_q] : 8'h00;
  assign int_rdata = imem[int_addr[7:0]];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [15:0] addr, input logic [7:0] wd,
                        input int exp_stb, input bit exp_int, input logic [7:0] exp_rd);
    int n = 0, n_ale = 0, n_stb = 0, n_int = 0;
    bit prev_ale = 0, lane_ok = 1, hold_ok = 1;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    forever begin
      @(negedge clk);
      n++;
      if (ale) begin
        n_ale++;
        if (ad_o != addr[7:0] || ah_o != addr[15:8]) lane_ok = 0;
      end
      if (prev_ale && !ale && (!ad_oe || ad_o != addr[7:0])) hold_ok = 0;
      prev_ale = ale;
      if (!rd_n) begin
        n_stb++;
        check(!ad_oe && ad_keep == (cfg_keeper && !cfg_compat), "R5 R10 lane released on read", ad_oe, 0);
      end
      if (!wr_n) begin
        n_stb++;
        check(ad_oe && ad_o == wd, "R6 write data on lane", ad_o, wd);
      end
      if (int_en) n_int++;
      if (cpu_ready || n > 20) break;
    end
    cpu_req = 0;
    if (!we) check(cpu_rdata == exp_rd, "R5 read data", cpu_rdata, exp_rd);
    check(n_stb == exp_stb, "R4 R7 R11 strobe length", n_stb, exp_stb);
    check(n_int == int'(exp_int), "R2 internal select", n_int, exp_int);
    check(n == 3 + (exp_stb == 0 ? 1 : exp_stb), "R4 ready latency", n, 3 + exp_stb);
    check(n_ale == int'(cfg_en) && lane_ok && hold_ok, "R3 address phase", n_ale, cfg_en);
  endtask

  typedef struct packed {
    logic we; logic [15:0] addr; logic [7:0] wd; logic [3:0] split;
    logic [1:0] wlo; logic [1:0] whi; logic cmp; logic [2:0] stb; logic [7:0] rd;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 16'h2010, 8'hA5, 4'd4, 2'd1, 2'd3, 1'b0, 3'd2, 8'h00},
    '{1'b0, 16'h2010, 8'h00, 4'd4, 2'd1, 2'd3, 1'b0, 3'd2, 8'hA5},
    '{1'b1, 16'h8020, 8'h3C, 4'd4, 2'd1, 2'd3, 1'b0, 3'd4, 8'h00},
    '{1'b0, 16'h8020, 8'h00, 4'd4, 2'd1, 2'd3, 1'b0, 3'd4, 8'h3C},
    '{1'b1, 16'h0140, 8'h77, 4'd4, 2'd1, 2'd3, 1'b0, 3'd0, 8'h00},
    '{1'b0, 16'h0140, 8'h00, 4'd4, 2'd1, 2'd3, 1'b0, 3'd0, 8'h77},
    '{1'b1, 16'h10FF, 8'h11, 4'd0, 2'd3, 2'd0, 1'b0, 3'd0, 8'h00},
    '{1'b0, 16'h10FF, 8'h00, 4'd0, 2'd3, 2'd0, 1'b0, 3'd0, 8'h11},
    '{1'b1, 16'h1100, 8'h22, 4'd0, 2'd3, 2'd0, 1'b0, 3'd1, 8'h00},
    '{1'b0, 16'h1100, 8'h00, 4'd0, 2'd3, 2'd0, 1'b0, 3'd1, 8'h22},
    '{1'b0, 16'h2010, 8'h00, 4'd4, 2'd0, 2'd3, 1'b1, 3'd2, 8'hA5},
    '{1'b0, 16'h2010, 8'h00, 4'd4, 2'd0, 2'd2, 1'b1, 3'd1, 8'hA5}
  };

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!cpu_ready && !ale && rd_n && wr_n && !ad_oe, "R1 reset state", {cpu_ready, ale, rd_n, wr_n, ad_oe}, 5'b00110);
    rst_n = 1;

    foreach (VECS[i]) begin
      cfg_split = VECS[i].split; cfg_ws_lo = VECS[i].wlo;
      cfg_ws_hi = VECS[i].whi; cfg_compat = VECS[i].cmp;
      access(VECS[i].we, VECS[i].addr, VECS[i].wd, int'(VECS[i].stb),
             VECS[i].stb == 0, VECS[i].rd);
    end

    cfg_compat = 0; cfg_split = 0; cfg_ws_hi = 0;
    access(1'b1, 16'h4033, 8'h5E, 1, 1'b0, 8'h00);
    @(negedge clk);
    check(ad_keep && !ad_oe && ad_o == 8'h5E, "R10 keeper holds last value", ad_o, 8'h5E);
    cfg_keeper = 0;
    @(negedge clk);
    check(!ad_keep, "R10 keeper off", ad_keep, 0);
    cfg_keeper = 1; cfg_compat = 1;
    @(negedge clk);
    check(!ad_keep && ah_oe == 8'hFF, "R11 compat keeper off, full high byte", ah_oe, 8'hFF);
    cfg_compat = 0;

    cfg_hi_rel = 3;
    @(negedge clk);
    check(ah_oe == 8'h1F, "R9 three high bits released", ah_oe, 8'h1F);
    cfg_hi_rel = 0;
    @(negedge clk);
    check(ah_oe == 8'hFF, "R9 all high bits driven", ah_oe, 8'hFF);

    cfg_en = 0;
    @(negedge clk);
    check(!ad_oe && ah_oe == 8'h00 && !ctl_oe && !ale, "R8 pins released", ah_oe, 0);
    access(1'b0, 16'h8020, 8'h00, 0, 1'b0, 8'h00);
    access(1'b0, 16'h0140, 8'h00, 0, 1'b1, 8'h77);
    cfg_en = 1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule